// File: doc/BRIEF.md
# Dual-Loop Status Pin Multiplexer

This block owns the single multi-purpose status pin of a two-loop frequency synthesizer. Each loop (RF1 and RF2) carries a two-bit status selector in its reference word: a "high" bit and a "low" bit. The block decodes the four selector bits jointly. It then drives the pin with one of several sources: a lock indication, a loop's reference divider strobe, a loop's programmable divider strobe, or the fastlock resistor switch control. It can also drive the pin to a steady low.

Some selector combinations choose no pin source and act on the loops instead. They request a reset of a loop's R and N counters and force that loop's charge pump into tri-state. The counter resets are released together, and each charge pump stays tri-stated for a few clocks after its counter reset falls. The counters therefore restart in step before the pump can drive again.

Selector bits arrive staged from the serial load path. They take effect only on the latch-enable strobe. All outputs are registered on the system clock. All interfaces are plain level signals; no data stream passes through the block.

Top module: `status_pin_mux`

## Requirements
- R1: Staged selector bits are captured only in a clock cycle where `le_i` is high; with `le_i` low, changes on `rf1_cfg_i`/`rf2_cfg_i` have no effect on any output.
- R2: With all four selector bits zero (bit [1] = high bit, bit [0] = low bit of each loop's selector), `status_o` is driven 0.
- R3: With both high bits zero and only one loop's low bit set, `status_o` follows that loop's lock flag (`lock_i[0]` = RF1, `lock_i[1]` = RF2).
- R4: With both high bits zero and both low bits set, `status_o` is 1 only when both loops are locked.
- R5: With exactly one loop's high bit set and that loop's low bit clear, `status_o` follows that loop's `refdiv_i` bit; the other loop's low bit is ignored.
- R6: With exactly one loop's high bit set and that loop's low bit set, `status_o` follows that loop's `progdiv_i` bit; the other loop's low bit is ignored.
- R7: With both high bits set and both low bits clear (fastlock), `status_o` is 1 while either loop's `cp_mag_i` bit is 1.
- R8: With both high bits set, the low bits pick the counter reset targets: RF1 low bit alone resets RF1, RF2 low bit alone resets RF2, both reset both. The affected `cnt_clr_o` bits are 1 and `status_o` is 0.
- R9: `cp_tri_o` of a loop is 1 whenever its `cnt_clr_o` is 1. It stays 1 for TRI_HOLD (default 2) further clocks after `cnt_clr_o` falls, then returns to 0.
- R10: Leaving the joint reset mode releases both loops' `cnt_clr_o` on the same clock edge.
- R11: Outputs are registered. A source input change appears on `status_o` one clock later. A new selector appears two clocks after the `le_i` edge. After reset, `status_o`, `cnt_clr_o` and `cp_tri_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| le_i | input | 1 | Latch strobe for staged selector bits |
| rf1_cfg_i | input | 2 | RF1 staged selector, [1] high bit, [0] low bit |
| rf2_cfg_i | input | 2 | RF2 staged selector, [1] high bit, [0] low bit |
| lock_i | input | 2 | Lock flags, [0] RF1, [1] RF2 |
| refdiv_i | input | 2 | Reference divider strobes, [0] RF1, [1] RF2 |
| progdiv_i | input | 2 | Programmable divider strobes, [0] RF1, [1] RF2 |
| cp_mag_i | input | 2 | Charge pump magnitude bits, [0] RF1, [1] RF2 |
| status_o | output | 1 | Registered status pin value |
| cnt_clr_o | output | 2 | R/N counter reset requests, [0] RF1, [1] RF2 |
| cp_tri_o | output | 2 | Charge pump tri-state requests, [0] RF1, [1] RF2 |

## Verification
The assertions assume `rst_ni` is held low for at least one clock edge before any check counts. They also assume `le_i` is a synchronous level sampled on the rising edge, so the selector register is the only path from the staged bits. The stimulus changes the selectors, `le_i` and all source inputs only at falling edges, and pulses `le_i` for exactly one clock per load. After each load the stimulus waits past the tri-state hold before sweeping all 256 source combinations. This keeps the steady-state checks clear of the release window, which is covered by its own cycle-by-cycle sequence.

// File: rtl/status_mux_pkg.sv
package status_mux_pkg;
  localparam int NLOOP = 2;

  typedef enum logic [3:0] {
    SM_OFF,
    SM_LOCK_A,
    SM_LOCK_B,
    SM_LOCK_AB,
    SM_REF_A,
    SM_REF_B,
    SM_PROG_A,
    SM_PROG_B,
    SM_FAST,
    SM_CLR_A,
    SM_CLR_B,
    SM_CLR_AB
  } smode_e;

  typedef logic [NLOOP-1:0][1:0] cfg_arr_t;
endpackage

// File: rtl/smux_cfg_latch.sv
module smux_cfg_latch
  import status_mux_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     le_i,
  input  cfg_arr_t cfg_d_i,
  output cfg_arr_t cfg_q_o
);
  cfg_arr_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (le_i) cfg_q <= cfg_d_i;
  end

  assign cfg_q_o = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_i |=> $stable(cfg_q_o)); // R1
endmodule

// File: rtl/smux_decode.sv
module smux_decode
  import status_mux_pkg::*;
(
  input  cfg_arr_t cfg_i,
  output smode_e   mode_o
);
  logic [NLOOP-1:0] hi;
  logic [NLOOP-1:0] lo;

  generate
    for (genvar g = 0; g < NLOOP; g++) begin : g_split
      assign hi[g] = cfg_i[g][1];
      assign lo[g] = cfg_i[g][0];
    end
  endgenerate

  always_comb begin
    mode_o = SM_OFF;
    unique case (hi)
      2'b00: begin
        unique case (lo)
          2'b00:   mode_o = SM_OFF;
          2'b01:   mode_o = SM_LOCK_A;
          2'b10:   mode_o = SM_LOCK_B;
          default: mode_o = SM_LOCK_AB;
        endcase
      end
      2'b01:   mode_o = lo[0] ? SM_PROG_A : SM_REF_A;
      2'b10:   mode_o = lo[1] ? SM_PROG_B : SM_REF_B;
      default: begin
        unique case (lo)
          2'b00:   mode_o = SM_FAST;
          2'b01:   mode_o = SM_CLR_A;
          2'b10:   mode_o = SM_CLR_B;
          default: mode_o = SM_CLR_AB;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/smux_drive.sv
module smux_drive
  import status_mux_pkg::*;
#(
  parameter int TRI_HOLD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  smode_e           mode_i,
  input  logic [NLOOP-1:0] lock_i,
  input  logic [NLOOP-1:0] refdiv_i,
  input  logic [NLOOP-1:0] progdiv_i,
  input  logic [NLOOP-1:0] cp_mag_i,
  output logic             pin_o,
  output logic [NLOOP-1:0] clr_o,
  output logic [NLOOP-1:0] tri_o
);
  localparam int HOLD_W = (TRI_HOLD > 0) ? $clog2(TRI_HOLD + 1) : 1;

  logic             pin_nx;
  logic [NLOOP-1:0] clr_req;

  always_comb begin
    pin_nx = 1'b0;
    unique case (mode_i)
      SM_LOCK_A:  pin_nx = lock_i[0];
      SM_LOCK_B:  pin_nx = lock_i[1];
      SM_LOCK_AB: pin_nx = &lock_i;
      SM_REF_A:   pin_nx = refdiv_i[0];
      SM_REF_B:   pin_nx = refdiv_i[1];
      SM_PROG_A:  pin_nx = progdiv_i[0];
      SM_PROG_B:  pin_nx = progdiv_i[1];
      SM_FAST:    pin_nx = |cp_mag_i;
      default:    pin_nx = 1'b0;
    endcase
  end

  assign clr_req[0] = (mode_i == SM_CLR_A) || (mode_i == SM_CLR_AB);
  assign clr_req[1] = (mode_i == SM_CLR_B) || (mode_i == SM_CLR_AB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_o <= 1'b0;
    else         pin_o <= pin_nx;
  end

  generate
    for (genvar g = 0; g < NLOOP; g++) begin : g_loop
      logic [HOLD_W-1:0] hold_cnt;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          clr_o[g]  <= 1'b0;
          tri_o[g]  <= 1'b0;
          hold_cnt  <= '0;
        end else begin
          clr_o[g] <= clr_req[g];
          tri_o[g] <= clr_req[g] || (hold_cnt != '0);
          if (clr_req[g])           hold_cnt <= HOLD_W'(TRI_HOLD);
          else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
        end
      end

      AST_CLR_TRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_o[g] |-> tri_o[g]); // R9

      if (TRI_HOLD > 0) begin : g_hold_chk
        AST_TRI_AFTER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
          $fell(clr_o[g]) |-> tri_o[g]); // R9
      end
    end
  endgenerate

  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_OFF) |=> !pin_o); // R2

  AST_PAIR_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_LOCK_AB && !(&lock_i)) |=> !pin_o); // R4

  AST_CLR_PIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_req) |=> (!pin_o && (clr_o != '0))); // R8
endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux
  import status_mux_pkg::*;
#(
  parameter int TRI_HOLD = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       le_i,
  input  logic [1:0] rf1_cfg_i,
  input  logic [1:0] rf2_cfg_i,
  input  logic [1:0] lock_i,
  input  logic [1:0] refdiv_i,
  input  logic [1:0] progdiv_i,
  input  logic [1:0] cp_mag_i,
  output logic       status_o,
  output logic [1:0] cnt_clr_o,
  output logic [1:0] cp_tri_o
);
  cfg_arr_t cfg_d;
  cfg_arr_t cfg_q;
  smode_e   mode;

  assign cfg_d[0] = rf1_cfg_i;
  assign cfg_d[1] = rf2_cfg_i;

  smux_cfg_latch i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .le_i    (le_i),
    .cfg_d_i (cfg_d),
    .cfg_q_o (cfg_q)
  );

  smux_decode i_decode (
    .cfg_i  (cfg_q),
    .mode_o (mode)
  );

  smux_drive #(.TRI_HOLD(TRI_HOLD)) i_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .lock_i    (lock_i),
    .refdiv_i  (refdiv_i),
    .progdiv_i (progdiv_i),
    .cp_mag_i  (cp_mag_i),
    .pin_o     (status_o),
    .clr_o     (cnt_clr_o),
    .tri_o     (cp_tri_o)
  );

  AST_JOINT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_clr_o == 2'b11) |=> (cnt_clr_o != 2'b00 || cp_tri_o == 2'b11)); // R10
endmodule

// File: tb/test_status_pin_mux.sv
module test_status_pin_mux;
  localparam int HOLD = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       le = 1'b0;
  logic [1:0] rf1_cfg = '0, rf2_cfg = '0;
  logic [1:0] lock = '0, refdiv = '0, progdiv = '0, mag = '0;
  logic       status;
  logic [1:0] clr, tri_s;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  status_pin_mux #(.TRI_HOLD(HOLD)) i_status_pin_mux (
    .clk_i(clk), .rst_ni(rst_n), .le_i(le),
    .rf1_cfg_i(rf1_cfg), .rf2_cfg_i(rf2_cfg),
    .lock_i(lock), .refdiv_i(refdiv), .progdiv_i(progdiv), .cp_mag_i(mag),
    .status_o(status), .cnt_clr_o(clr), .cp_tri_o(tri_s)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // code bits: [3] RF1 high, [2] RF2 high, [1] RF1 low, [0] RF2 low
  function automatic logic exp_pin(input logic [3:0] c, input logic [7:0] v);
    logic [1:0] lk, rf, pg, mg;
    lk = v[1:0]; rf = v[3:2]; pg = v[5:4]; mg = v[7:6];
    case ({c[2], c[3]})
      2'b00: case ({c[0], c[1]})
               2'b00: return 1'b0;
               2'b01: return lk[0];
               2'b10: return lk[1];
               default: return lk[0] & lk[1];
             endcase
      2'b01: return c[1] ? pg[0] : rf[0];
      2'b10: return c[0] ? pg[1] : rf[1];
      default: return ({c[1], c[0]} == 2'b00) ? (mg[0] | mg[1]) : 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] exp_clr(input logic [3:0] c);
    if (c[3] && c[2]) return {c[0], c[1]};
    return 2'b00;
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case ({c[2], c[3]})
      2'b00: return (c[1:0] == 2'b00) ? "R2" : (c[1:0] == 2'b11) ? "R4" : "R3";
      2'b01: return c[1] ? "R6" : "R5";
      2'b10: return c[0] ? "R6" : "R5";
      default: return (c[1:0] == 2'b00) ? "R7" : "R8";
    endcase
  endfunction

  task automatic load(input logic [3:0] c);
    @(negedge clk);
    rf1_cfg = {c[3], c[1]};
    rf2_cfg = {c[2], c[0]};
    le = 1'b1;
    @(negedge clk);
    le = 1'b0;
  endtask

  task automatic set_src(input logic [7:0] v);
    lock = v[1:0]; refdiv = v[3:2]; progdiv = v[5:4]; mag = v[7:6];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset status", {1'b0, status}, 2'b00);
    chk("R11 reset clr", clr, 2'b00);
    chk("R11 reset tri", tri_s, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive sweep: every selector code, every source combination
    for (int c = 0; c < 16; c++) begin
      load(4'(c));
      repeat (HOLD + 3) @(negedge clk);
      for (int v = 0; v < 256; v++) begin
        set_src(8'(v));
        @(negedge clk);
        chk(req_of(4'(c)), {1'b0, status}, {1'b0, exp_pin(4'(c), 8'(v))});
        chk("R8 clr", clr, exp_clr(4'(c)));
        chk("R9 tri steady", tri_s, exp_clr(4'(c)));
      end
    end

    // R1: staged change without strobe is ignored
    load(4'b0010);
    set_src(8'h01);
    repeat (3) @(negedge clk);
    chk("R1 before", {1'b0, status}, 2'b01);
    rf1_cfg = 2'b11; rf2_cfg = 2'b11;
    repeat (4) @(negedge clk);
    chk("R1 pin held", {1'b0, status}, 2'b01);
    chk("R1 no clr", clr, 2'b00);
    chk("R1 no tri", tri_s, 2'b00);

    // R11: mode latency two edges after strobe, source latency one edge
    load(4'b0000);
    repeat (2) @(negedge clk);
    set_src(8'h01);
    @(negedge clk);
    rf1_cfg = 2'b01; rf2_cfg = 2'b00; le = 1'b1;
    @(negedge clk);
    le = 1'b0;
    chk("R11 mode edge1", {1'b0, status}, 2'b00);
    @(negedge clk);
    chk("R11 mode edge2", {1'b0, status}, 2'b01);
    set_src(8'h00);
    @(negedge clk);
    chk("R11 source edge1", {1'b0, status}, 2'b00);

    // R9 / R10: release timing out of joint reset
    load(4'b1111);
    repeat (HOLD + 3) @(negedge clk);
    chk("R8 joint clr", clr, 2'b11);
    rf1_cfg = 2'b00; rf2_cfg = 2'b00; le = 1'b1;
    @(negedge clk);
    le = 1'b0;
    chk("R10 edge1 clr", clr, 2'b11);
    @(negedge clk);
    chk("R10 joint release", clr, 2'b00);
    chk("R9 hold1", tri_s, 2'b11);
    for (int k = 1; k < HOLD; k++) begin
      @(negedge clk);
      chk("R9 hold", tri_s, 2'b11);
    end
    @(negedge clk);
    chk("R9 released", tri_s, 2'b00);

    // R9: single-loop reset release on RF2
    load(4'b1101);
    repeat (HOLD + 3) @(negedge clk);
    chk("R8 rf2 clr", clr, 2'b10);
    load(4'b0000);
    @(negedge clk);
    chk("R9 rf2 hold", {clr[1], tri_s[1]}, 2'b01);
    repeat (HOLD) @(negedge clk);
    chk("R9 rf2 released", tri_s, 2'b00);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule